// File: doc/BRIEF.md
# Single-Precision Compare, Min/Max and Classify Unit

A purely combinational unit that handles the non-arithmetic single-precision float operations of a core that keeps float values in its integer registers. Operands and results are raw 32-bit words. An operation code, split into a 7-bit major field and a 3-bit minor field, selects one of nine operations: minimum, maximum, equal, less-than, less-or-equal, three sign-injection variants, and classification. There is no handshake. The result, an invalid-operation flag and an illegal-operation flag are valid in the same cycle as the inputs.

Before any operation, a subnormal operand is replaced by a zero with the same sign. Every operation, classification included, therefore sees subnormals as signed zeros. Minimum and maximum follow the RISC-V rules: a NaN operand is skipped, and negative zero ranks below positive zero.

Top module: `fp32_cmp_unit`

## Requirements
- R1: An operand with exponent field zero and a nonzero fraction is replaced by a zero of the same sign before the selected operation is evaluated.
- R2: Major code 0010100 with minor 000 returns the lesser operand and with minor 001 the greater operand, ordered by numeric value.
- R3: For min/max, if both operands are NaN the result is 0x7FC00000; if exactly one is NaN, the other (flushed) operand is returned.
- R4: Min/max rank -0 below +0: min(+0,-0) = 0x80000000 and max(+0,-0) = 0x00000000.
- R5: Major code 1010000 with minor 010, 001, 000 gives equal, less-than and less-or-equal as integer 1 or 0. Any NaN operand gives 0, and +0 equals -0.
- R6: Major code 0010000 returns the magnitude of operand A. Its sign is B's sign for minor 000, the inverse of B's sign for minor 001, and the XOR of both signs for minor 010.
- R7: Major code 1110000 with minor 001 returns a one-hot 10-bit mask of operand A in bits 9:0, with bits 31:10 zero. Bit 0 is -inf, 1 -normal, 2 -subnormal, 3 -0, 4 +0, 5 +subnormal, 6 +normal, 7 +inf, 8 signalling NaN, 9 quiet NaN. A NaN is quiet when fraction bit 22 is set.
- R8: Because of the flush, classification never sets bits 2 or 5; a subnormal reports as a zero of its own sign.
- R9: The invalid flag is set when a signalling NaN reaches min, max or equal, or when any NaN reaches less-than or less-or-equal; it is clear otherwise.
- R10: Any other code combination sets the illegal output and forces the result to zero with the invalid flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 32 | First operand (raw single-precision word) |
| op_b | input | 32 | Second operand (raw single-precision word) |
| funct7 | input | 7 | Major operation code |
| funct3 | input | 3 | Minor operation code |
| result | output | 32 | Operation result |
| invalid | output | 1 | Invalid-operation flag |
| illegal | output | 1 | Unrecognised operation code |

## Verification
Two outputs can change in the same cycle: a data result and the invalid flag. Ordered comparisons on a NaN and min/max on a signalling NaN drive both at once. The bench applies such operands and checks, at the same sample point, that a valid result and the flag both appear. Examples are max with a signalling NaN returning the other operand while the flag is set, and less-or-equal on a quiet NaN returning 0 while the flag is set. The opposite case is also covered: a signalling NaN under an illegal code must leave the flag clear while illegal is set.

// File: rtl/fp32_cmp_unit.sv
module fp32_cmp_unit (
  input  logic [31:0] op_a,
  input  logic [31:0] op_b,
  input  logic [6:0]  funct7,
  input  logic [2:0]  funct3,
  output logic [31:0] result,
  output logic        invalid,
  output logic        illegal
);
  localparam logic [6:0]  F7_MINMAX = 7'b0010100;
  localparam logic [6:0]  F7_CMP    = 7'b1010000;
  localparam logic [6:0]  F7_SGN    = 7'b0010000;
  localparam logic [6:0]  F7_CLASS  = 7'b1110000;
  localparam logic [31:0] CANON_NAN = 32'h7FC0_0000;

  logic [31:0] a, b;
  assign a = (op_a[30:23] == 8'd0) ? {op_a[31], 31'd0} : op_a;
  assign b = (op_b[30:23] == 8'd0) ? {op_b[31], 31'd0} : op_b;

  logic nan_a, nan_b, snan_a, snan_b, any_nan, any_snan;
  assign nan_a    = (&a[30:23]) && (|a[22:0]);
  assign nan_b    = (&b[30:23]) && (|b[22:0]);
  assign snan_a   = nan_a && !a[22];
  assign snan_b   = nan_b && !b[22];
  assign any_nan  = nan_a || nan_b;
  assign any_snan = snan_a || snan_b;

  logic both_zero, total_lt, num_lt, num_eq;
  assign both_zero = (a[30:0] == 31'd0) && (b[30:0] == 31'd0);
  assign total_lt  = (a[31] != b[31]) ? a[31] :
                     (a[31] ? (b[30:0] < a[30:0]) : (a[30:0] < b[30:0]));
  assign num_lt    = total_lt && !both_zero;
  assign num_eq    = both_zero || (a == b);

  logic a_inf, a_norm, a_sub, a_zero;
  logic [9:0] cls;
  assign a_inf  = (&a[30:23]) && (a[22:0] == 23'd0);
  assign a_norm = (a[30:23] != 8'd0) && !(&a[30:23]);
  assign a_sub  = (a[30:23] == 8'd0) && (a[22:0] != 23'd0);
  assign a_zero = (a[30:0] == 31'd0);
  assign cls = {nan_a && a[22], snan_a,
                !a[31] && a_inf, !a[31] && a_norm, !a[31] && a_sub, !a[31] && a_zero,
                a[31] && a_zero, a[31] && a_sub, a[31] && a_norm, a[31] && a_inf};

  always_comb begin
    result  = 32'd0;
    invalid = 1'b0;
    illegal = 1'b0;
    case ({funct7, funct3})
      {F7_MINMAX, 3'b000}, {F7_MINMAX, 3'b001}: begin
        invalid = any_snan;
        if (nan_a && nan_b)  result = CANON_NAN;
        else if (nan_a)      result = b;
        else if (nan_b)      result = a;
        else if (funct3[0])  result = total_lt ? b : a;
        else                 result = total_lt ? a : b;
      end
      {F7_CMP, 3'b010}: begin
        invalid = any_snan;
        result  = {31'd0, !any_nan && num_eq};
      end
      {F7_CMP, 3'b001}: begin
        invalid = any_nan;
        result  = {31'd0, !any_nan && num_lt};
      end
      {F7_CMP, 3'b000}: begin
        invalid = any_nan;
        result  = {31'd0, !any_nan && (num_lt || num_eq)};
      end
      {F7_SGN, 3'b000}: result = {b[31], a[30:0]};
      {F7_SGN, 3'b001}: result = {~b[31], a[30:0]};
      {F7_SGN, 3'b010}: result = {a[31] ^ b[31], a[30:0]};
      {F7_CLASS, 3'b001}: result = {22'd0, cls};
      default: illegal = 1'b1;
    endcase
  end

  always_comb begin
    // R10
    illegal_quiet_chk: assert (!illegal || (result == 32'd0 && !invalid));
    // R7
    class_onehot_chk: assert (!(funct7 == F7_CLASS && funct3 == 3'b001) ||
                              ($onehot(result[9:0]) && result[31:10] == 22'd0));
    // R8
    class_nosub_chk: assert (!(funct7 == F7_CLASS && funct3 == 3'b001) ||
                             (!result[2] && !result[5]));
    // R5
    cmp_bool_chk: assert (funct7 != F7_CMP || illegal || result[31:1] == 31'd0);
    // R3
    minmax_nan_chk: assert (!(funct7 == F7_MINMAX && !illegal && nan_a && nan_b) ||
                            result == CANON_NAN);
    // R9
    invalid_src_chk: assert (!invalid || any_nan);
  end
endmodule

// File: tb/fp32_cmp_unit_bench.sv
module fp32_cmp_unit_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] op_a = 32'd0, op_b = 32'd0;
  logic [6:0]  funct7 = 7'd0;
  logic [2:0]  funct3 = 3'd0;
  logic [31:0] result;
  logic        invalid, illegal;

  fp32_cmp_unit u_fp32_cmp_unit (
    .op_a(op_a), .op_b(op_b), .funct7(funct7), .funct3(funct3),
    .result(result), .invalid(invalid), .illegal(illegal)
  );

  int tests = 0, fails = 0;
  logic done = 1'b0;

  localparam int NV = 35;
  // {req, funct7, funct3, a, b, result, invalid, illegal}
  localparam logic [111:0] VEC [NV] = '{
    {4'd2,  7'b0010100, 3'b000, 32'h3F800000, 32'h40000000, 32'h3F800000, 1'b0, 1'b0}, // R2
    {4'd2,  7'b0010100, 3'b001, 32'h3F800000, 32'h40000000, 32'h40000000, 1'b0, 1'b0}, // R2
    {4'd2,  7'b0010100, 3'b000, 32'hBF800000, 32'hC0000000, 32'hC0000000, 1'b0, 1'b0}, // R2
    {4'd2,  7'b0010100, 3'b001, 32'hBF800000, 32'hC0000000, 32'hBF800000, 1'b0, 1'b0}, // R2
    {4'd4,  7'b0010100, 3'b000, 32'h00000000, 32'h80000000, 32'h80000000, 1'b0, 1'b0}, // R4
    {4'd4,  7'b0010100, 3'b001, 32'h00000000, 32'h80000000, 32'h00000000, 1'b0, 1'b0}, // R4
    {4'd3,  7'b0010100, 3'b000, 32'h7FC00000, 32'h3F800000, 32'h3F800000, 1'b0, 1'b0}, // R3
    {4'd9,  7'b0010100, 3'b001, 32'h3F800000, 32'h7F800001, 32'h3F800000, 1'b1, 1'b0}, // R9 R3
    {4'd3,  7'b0010100, 3'b000, 32'h7FC00001, 32'h7F800001, 32'h7FC00000, 1'b1, 1'b0}, // R3
    {4'd3,  7'b0010100, 3'b001, 32'h80000000, 32'h7FC00000, 32'h80000000, 1'b0, 1'b0}, // R3
    {4'd5,  7'b1010000, 3'b010, 32'h3F800000, 32'h3F800000, 32'h00000001, 1'b0, 1'b0}, // R5
    {4'd5,  7'b1010000, 3'b010, 32'h00000000, 32'h80000000, 32'h00000001, 1'b0, 1'b0}, // R5
    {4'd5,  7'b1010000, 3'b001, 32'hBF800000, 32'h3F800000, 32'h00000001, 1'b0, 1'b0}, // R5
    {4'd5,  7'b1010000, 3'b001, 32'h3F800000, 32'h3F800000, 32'h00000000, 1'b0, 1'b0}, // R5
    {4'd5,  7'b1010000, 3'b000, 32'h3F800000, 32'h3F800000, 32'h00000001, 1'b0, 1'b0}, // R5
    {4'd9,  7'b1010000, 3'b000, 32'h7FC00000, 32'h3F800000, 32'h00000000, 1'b1, 1'b0}, // R9
    {4'd9,  7'b1010000, 3'b010, 32'h7FC00000, 32'h3F800000, 32'h00000000, 1'b0, 1'b0}, // R9
    {4'd6,  7'b0010000, 3'b000, 32'h3F800000, 32'h80000000, 32'hBF800000, 1'b0, 1'b0}, // R6
    {4'd6,  7'b0010000, 3'b001, 32'h3F800000, 32'h80000000, 32'h3F800000, 1'b0, 1'b0}, // R6
    {4'd6,  7'b0010000, 3'b010, 32'hBF800000, 32'h80000000, 32'h3F800000, 1'b0, 1'b0}, // R6
    {4'd7,  7'b1110000, 3'b001, 32'hFF800000, 32'h0, 32'h00000001, 1'b0, 1'b0}, // R7
    {4'd7,  7'b1110000, 3'b001, 32'hBF800000, 32'h0, 32'h00000002, 1'b0, 1'b0}, // R7
    {4'd7,  7'b1110000, 3'b001, 32'h80000000, 32'h0, 32'h00000008, 1'b0, 1'b0}, // R7
    {4'd7,  7'b1110000, 3'b001, 32'h00000000, 32'h0, 32'h00000010, 1'b0, 1'b0}, // R7
    {4'd7,  7'b1110000, 3'b001, 32'h3F800000, 32'h0, 32'h00000040, 1'b0, 1'b0}, // R7
    {4'd7,  7'b1110000, 3'b001, 32'h7F800000, 32'h0, 32'h00000080, 1'b0, 1'b0}, // R7
    {4'd7,  7'b1110000, 3'b001, 32'h7F800001, 32'h0, 32'h00000100, 1'b0, 1'b0}, // R7
    {4'd7,  7'b1110000, 3'b001, 32'h7FC00000, 32'h0, 32'h00000200, 1'b0, 1'b0}, // R7
    {4'd8,  7'b1110000, 3'b001, 32'h80000001, 32'h0, 32'h00000008, 1'b0, 1'b0}, // R8
    {4'd8,  7'b1110000, 3'b001, 32'h00400000, 32'h0, 32'h00000010, 1'b0, 1'b0}, // R8
    {4'd1,  7'b0010000, 3'b000, 32'h00400000, 32'h00000000, 32'h00000000, 1'b0, 1'b0}, // R1
    {4'd1,  7'b0010100, 3'b000, 32'h00000001, 32'h80000000, 32'h80000000, 1'b0, 1'b0}, // R1
    {4'd1,  7'b1010000, 3'b001, 32'h80000005, 32'h00000003, 32'h00000000, 1'b0, 1'b0}, // R1
    {4'd10, 7'b0010100, 3'b010, 32'h3F800000, 32'h40000000, 32'h00000000, 1'b0, 1'b1}, // R10
    {4'd10, 7'b1111111, 3'b000, 32'h7F800001, 32'h7F800001, 32'h00000000, 1'b0, 1'b1}  // R10
  };

  task automatic check(input int req, input logic [31:0] er, input logic ei, input logic el);
    tests++;
    if (result !== er || invalid !== ei || illegal !== el) begin
      fails++;
      $display("FAIL R%0d: got res=%h inv=%b ill=%b, exp res=%h inv=%b ill=%b",
               req, result, invalid, illegal, er, ei, el);
    end
  endtask

  task automatic apply(input logic [6:0] f7, input logic [2:0] f3,
                       input logic [31:0] a, input logic [31:0] b);
    @(posedge clk);
    funct7 = f7; funct3 = f3; op_a = a; op_b = b;
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    check(10, 32'd0, 1'b0, 1'b1); // R10 idle inputs: code 0 is illegal
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][107:101], VEC[i][100:98], VEC[i][97:66], VEC[i][65:34]);
      check(int'(VEC[i][111:108]), VEC[i][33:2], VEC[i][1], VEC[i][0]);
    end
    // R6 magnitude of a negative NaN kept under sign injection
    apply(7'b0010000, 3'b001, 32'hFFC00001, 32'h00000000);
    check(6, 32'hFFC00001, 1'b0, 1'b0);
    // R5 less-or-equal between -0 and +0
    apply(7'b1010000, 3'b000, 32'h00000000, 32'h80000000);
    check(5, 32'h00000001, 1'b0, 1'b0);
    // R9 less-than with signalling NaN
    apply(7'b1010000, 3'b001, 32'h3F800000, 32'hFF800001);
    check(9, 32'h00000000, 1'b1, 1'b0);
    // R2 large magnitudes across signs
    apply(7'b0010100, 3'b001, 32'hFF7FFFFF, 32'h00800000);
    check(2, 32'h00800000, 1'b0, 1'b0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (10000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule